// File: doc/BRIEF.md
# Interrupt Cause and Mask Group

This block is one group of a register-mapped interrupt controller serving a parameterized number of sources (32 by default). A source held high during a clock edge sets its cause bit, and the bit stays set until software clears it. A per-bit mask decides which pending causes reach the group interrupt line. A separate abort mask decides which pending causes raise the abort line. The interrupt mask has no effect on the abort line.

Software reaches the group through a single-cycle register port with one request per cycle. The write encodings avoid read-modify-write for the common cases. Cause bits are cleared by writing 0 to the cause register. Mask bits are cleared (unmasked) by writing 0 to a mask-clear alias. Software can raise causes by writing 1s to a cause-set register. Writing the control register stores a configuration word and also leaves every source masked.

Top module: `irq_cause_group`

## Requirements
- R1: After reset the mask reads all ones, and the cause, abort mask and control registers read zero. Both irq_o and abort_o are low.
- R2: A source bit high at a clock edge sets its cause bit at that edge. The bit stays set while the source is low and no clear is written.
- R3: A write to offset 1 (cause) clears each cause bit whose data bit is 0. Data bits of 1 leave their cause bits unchanged.
- R4: When a source bit is high in the same cycle as a cause write that clears it, the cause bit ends up set.
- R5: A write to offset 2 (cause-set) sets each cause bit whose data bit is 1. A read of offset 2 returns zero.
- R6: A write to offset 3 (mask) replaces the whole mask with the write data. A 1 in a bit means that bit is masked.
- R7: A write to offset 4 (mask-clear) clears each mask bit whose data bit is 0 and keeps the others. A read of offset 4 returns the current mask.
- R8: A write to offset 5 (abort mask) replaces the abort mask, and a read of offset 5 returns it.
- R9: A write to offset 0 (control) stores the data, which reads back at offset 0, and sets every mask bit to 1 in the same cycle.
- R10: irq_o equals the OR over all bits of (cause AND NOT mask), as that state stood one clock earlier.
- R11: abort_o equals the OR over all bits of (cause AND abort mask) in the current state, whatever the mask holds.
- R12: Read data appears on rdata_o one clock after a read request and holds until the next read. Offsets 6 and 7 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Source request lines, sampled every edge |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Register word offset |
| req_wdata | input | NUM_SRC | Write data |
| rdata_o | output | NUM_SRC | Registered read data |
| irq_o | output | 1 | Group interrupt, registered |
| abort_o | output | 1 | Abort request |

## Verification
Two collisions can happen in one cycle. A source request can meet a software clear of the same cause bit, and a control write can meet pending unmasked causes whose interrupt must then drop. The bench forces both in directed cycles: a cause write of all zeros while chosen sources are high, and a control write while the interrupt is active. It also provokes them by chance in a random phase where sparse source pulses overlap random cause, mask and control writes. A reference model that applies the clear before the source OR judges every cycle. The model checks irq_o, abort_o and all read data.

// File: rtl/irq_grp_pkg.sv
package irq_grp_pkg;

    localparam int unsigned OFS_CTRL      = 0;
    localparam int unsigned OFS_CAUSE     = 1;
    localparam int unsigned OFS_CAUSE_SET = 2;
    localparam int unsigned OFS_MASK      = 3;
    localparam int unsigned OFS_MASK_CLR  = 4;
    localparam int unsigned OFS_ABORT     = 5;
    localparam int unsigned NUM_OFS       = 6;

    typedef struct packed {
        logic ctrl;
        logic cause;
        logic cause_set;
        logic mask;
        logic mask_clr;
        logic abort;
    } wr_strobe_t;

endpackage

// File: rtl/irq_grp_decode.sv
module irq_grp_decode
    import irq_grp_pkg::*;
#(
    parameter int unsigned ADDR_W = 3
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output wr_strobe_t        wr_stb,
    output logic              rd_stb
);

    logic wr_any;

    always_comb begin
        wr_any           = req_valid && req_write;
        rd_stb           = req_valid && !req_write;
        wr_stb           = '0;
        wr_stb.ctrl      = wr_any && (req_addr == ADDR_W'(OFS_CTRL));
        wr_stb.cause     = wr_any && (req_addr == ADDR_W'(OFS_CAUSE));
        wr_stb.cause_set = wr_any && (req_addr == ADDR_W'(OFS_CAUSE_SET));
        wr_stb.mask      = wr_any && (req_addr == ADDR_W'(OFS_MASK));
        wr_stb.mask_clr  = wr_any && (req_addr == ADDR_W'(OFS_MASK_CLR));
        wr_stb.abort     = wr_any && (req_addr == ADDR_W'(OFS_ABORT));
    end

endmodule

// File: rtl/irq_grp_state.sv
module irq_grp_state
    import irq_grp_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  wr_strobe_t         wr_stb,
    input  logic [NUM_SRC-1:0] wdata,
    output logic [NUM_SRC-1:0] cause_q,
    output logic [NUM_SRC-1:0] mask_q,
    output logic [NUM_SRC-1:0] abort_q,
    output logic [NUM_SRC-1:0] ctrl_q
);

    typedef struct packed {
        logic [NUM_SRC-1:0] cause;
        logic [NUM_SRC-1:0] mask;
        logic [NUM_SRC-1:0] abort;
        logic [NUM_SRC-1:0] ctrl;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // software clear first, then software set, then hardware sources win
        if (wr_stb.cause)     st_d.cause = st_d.cause & wdata;
        if (wr_stb.cause_set) st_d.cause = st_d.cause | wdata;
        st_d.cause = st_d.cause | src_i;

        if (wr_stb.mask)      st_d.mask = wdata;
        if (wr_stb.mask_clr)  st_d.mask = st_q.mask & wdata;
        if (wr_stb.ctrl) begin
            st_d.ctrl = wdata;
            st_d.mask = '1;
        end
        if (wr_stb.abort)     st_d.abort = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cause <= '0;
            st_q.mask  <= '1;
            st_q.abort <= '0;
            st_q.ctrl  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cause_q = st_q.cause;
    assign mask_q  = st_q.mask;
    assign abort_q = st_q.abort;
    assign ctrl_q  = st_q.ctrl;

endmodule

// File: rtl/irq_grp_readmux.sv
module irq_grp_readmux
    import irq_grp_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned ADDR_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_stb,
    input  logic [ADDR_W-1:0]  rd_addr,
    input  logic [NUM_SRC-1:0] cause_q,
    input  logic [NUM_SRC-1:0] mask_q,
    input  logic [NUM_SRC-1:0] abort_q,
    input  logic [NUM_SRC-1:0] ctrl_q,
    output logic [NUM_SRC-1:0] rdata_o
);

    localparam int unsigned SEL_W = $clog2(NUM_OFS);

    logic [NUM_OFS-1:0][NUM_SRC-1:0] view;
    logic [NUM_SRC-1:0]              rdata_d, rdata_q;

    always_comb begin
        view                = '0;
        view[OFS_CTRL]      = ctrl_q;
        view[OFS_CAUSE]     = cause_q;
        view[OFS_CAUSE_SET] = '0;
        view[OFS_MASK]      = mask_q;
        view[OFS_MASK_CLR]  = mask_q;
        view[OFS_ABORT]     = abort_q;
    end

    always_comb begin
        rdata_d = rdata_q;
        if (rd_stb) begin
            if (int'(rd_addr) < NUM_OFS)
                rdata_d = view[rd_addr[SEL_W-1:0]];
            else
                rdata_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/irq_grp_outputs.sv
module irq_grp_outputs #(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] cause_q,
    input  logic [NUM_SRC-1:0] mask_q,
    input  logic [NUM_SRC-1:0] abort_q,
    output logic               irq_o,
    output logic               abort_o
);

    logic irq_d, irq_q;

    always_comb begin
        irq_d   = |(cause_q & ~mask_q);
        abort_o = |(cause_q & abort_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/irq_cause_group.sv
module irq_cause_group
    import irq_grp_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned ADDR_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [NUM_SRC-1:0] req_wdata,
    output logic [NUM_SRC-1:0] rdata_o,
    output logic               irq_o,
    output logic               abort_o
);

    wr_strobe_t         wr_stb;
    logic               rd_stb;
    logic [NUM_SRC-1:0] cause_q, mask_q, abort_q, ctrl_q;

    irq_grp_decode #(.ADDR_W(ADDR_W)) u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .wr_stb    (wr_stb),
        .rd_stb    (rd_stb)
    );

    irq_grp_state #(.NUM_SRC(NUM_SRC)) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (src_i),
        .wr_stb  (wr_stb),
        .wdata   (req_wdata),
        .cause_q (cause_q),
        .mask_q  (mask_q),
        .abort_q (abort_q),
        .ctrl_q  (ctrl_q)
    );

    irq_grp_readmux #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_read (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_stb  (rd_stb),
        .rd_addr (req_addr),
        .cause_q (cause_q),
        .mask_q  (mask_q),
        .abort_q (abort_q),
        .ctrl_q  (ctrl_q),
        .rdata_o (rdata_o)
    );

    irq_grp_outputs #(.NUM_SRC(NUM_SRC)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .cause_q (cause_q),
        .mask_q  (mask_q),
        .abort_q (abort_q),
        .irq_o   (irq_o),
        .abort_o (abort_o)
    );

endmodule

// File: rtl/irq_cause_group_chk.sv
module irq_cause_group_chk
    import irq_grp_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned ADDR_W  = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_i,
    input logic               req_valid,
    input logic               req_write,
    input logic [ADDR_W-1:0]  req_addr,
    input logic [NUM_SRC-1:0] req_wdata,
    input logic [NUM_SRC-1:0] cause_q,
    input logic [NUM_SRC-1:0] mask_q,
    input logic               irq_o
);

    logic wr_cause, wr_ctrl, wr_mclr, wr_other;

    always_comb begin
        wr_cause = req_valid && req_write && (req_addr == ADDR_W'(OFS_CAUSE));
        wr_ctrl  = req_valid && req_write && (req_addr == ADDR_W'(OFS_CTRL));
        wr_mclr  = req_valid && req_write && (req_addr == ADDR_W'(OFS_MASK_CLR));
        wr_other = req_valid && req_write && (req_addr != ADDR_W'(OFS_CAUSE_SET));
    end

    assert_src_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i != '0) |=> ((cause_q & $past(src_i)) == $past(src_i)));

    assert_cause_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cause && src_i == '0) |=> (cause_q == ($past(cause_q) & $past(req_wdata))));

    assert_src_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cause && src_i != '0) |=> ((cause_q & $past(src_i)) == $past(src_i)));

    assert_mask_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mclr |=> (mask_q == ($past(mask_q) & $past(req_wdata))));

    assert_ctrl_masks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (mask_q == '1));

    assert_irq_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '1) |=> !irq_o);

    assert_cause_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i == '0 && !wr_other && !(req_valid && req_write)) |=> $stable(cause_q));

endmodule

bind irq_cause_group irq_cause_group_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src_i),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .cause_q   (cause_q),
    .mask_q    (mask_q),
    .irq_o     (irq_o)
);

// File: tb/tb_irq_cause_group.sv
module tb_irq_cause_group;

    localparam int unsigned N  = 32;
    localparam int unsigned AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_i = '0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [N-1:0]  req_wdata = '0;
    logic [N-1:0]  rdata_o;
    logic          irq_o, abort_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [N-1:0] m_cause, m_mask, m_abort, m_ctrl;

    always #4 clk = ~clk;

    irq_cause_group #(.NUM_SRC(N), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rdata_o(rdata_o), .irq_o(irq_o), .abort_o(abort_o)
    );

    function automatic logic [N-1:0] model_read(input logic [AW-1:0] a);
        case (a)
            3'd0: return m_ctrl;
            3'd1: return m_cause;
            3'd2: return '0;
            3'd3: return m_mask;
            3'd4: return m_mask;
            3'd5: return m_abort;
            default: return '0;
        endcase
    endfunction

    function automatic string read_tag(input logic [AW-1:0] a);
        case (a)
            3'd0: return "R9";
            3'd1: return "R2";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            3'd5: return "R8";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [N-1:0] act,
                         input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Called at a negedge; returns at the following negedge after checking.
    task automatic step(input logic [N-1:0] src, input bit vld, input bit we,
                        input logic [AW-1:0] a, input logic [N-1:0] wd);
        logic         exp_irq;
        logic [N-1:0] exp_rd;
        src_i = src; req_valid = vld; req_write = we; req_addr = a; req_wdata = wd;
        @(posedge clk);
        exp_irq = |(m_cause & ~m_mask);
        exp_rd  = model_read(a);
        if (vld && we) begin
            case (a)
                3'd0: begin m_ctrl = wd; m_mask = '1; end
                3'd1: m_cause = m_cause & wd;
                3'd2: m_cause = m_cause | wd;
                3'd3: m_mask = wd;
                3'd4: m_mask = m_mask & wd;
                3'd5: m_abort = wd;
                default: ;
            endcase
        end
        m_cause = m_cause | src;
        @(negedge clk);
        check(irq_o == exp_irq, "R10 irq", N'(irq_o), N'(exp_irq));
        check(abort_o == |(m_cause & m_abort), "R11 abort", N'(abort_o),
              N'(|(m_cause & m_abort)));
        if (vld && !we)
            check(rdata_o == exp_rd, read_tag(a), rdata_o, exp_rd);
        src_i = '0; req_valid = 1'b0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [N-1:0] d);
        step('0, 1'b1, 1'b1, a, d);
    endtask

    task automatic rd(input logic [AW-1:0] a);
        step('0, 1'b1, 1'b0, a, '0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [N-1:0] held;
        void'($urandom(32'd20240611));
        m_cause = '0; m_mask = '1; m_abort = '0; m_ctrl = '0;
        repeat (3) @(negedge clk);
        check(irq_o == 1'b0 && abort_o == 1'b0, "R1 outputs", N'({irq_o, abort_o}), '0);
        rst_n = 1'b1;

        // R1: reset values
        for (int a = 0; a < 6; a++) rd(AW'(a));
        check(m_mask == '1, "R1 mask model", m_mask, '1);

        // R2: sticky source
        step(32'h0000_0011, 1'b0, 1'b0, '0, '0);
        step('0, 1'b0, 1'b0, '0, '0);
        rd(3'd1);
        check(rdata_o == 32'h11, "R2 sticky", rdata_o, 32'h11);

        // R3: clear by writing zeros; ones leave bits alone
        wr(3'd1, 32'hFFFF_FFEF);
        rd(3'd1);
        check(rdata_o == 32'h01, "R3 clear", rdata_o, 32'h01);

        // R4: source beats simultaneous clear
        step(32'h8000_0001, 1'b1, 1'b1, 3'd1, 32'h0);
        rd(3'd1);
        check(rdata_o == 32'h8000_0001, "R4 collision", rdata_o, 32'h8000_0001);

        // R5: cause-set
        wr(3'd2, 32'h0000_0F00);
        rd(3'd2);
        check(rdata_o == '0, "R5 read zero", rdata_o, '0);

        // R6/R7: unmask, check irq, then mask-clear alias
        wr(3'd3, 32'hFFFF_FFFE);
        step('0, 1'b0, 1'b0, '0, '0);
        check(irq_o == 1'b1, "R10 irq high", N'(irq_o), 1);
        wr(3'd4, 32'h7FFF_FFFF);
        rd(3'd4);
        check(rdata_o == 32'h7FFF_FFFE, "R7 mask-clear", rdata_o, 32'h7FFF_FFFE);

        // R11: abort independent of mask
        wr(3'd3, '1);
        wr(3'd5, 32'h0000_0100);
        check(abort_o == 1'b1, "R11 abort masked", N'(abort_o), 1);

        // R9: control write re-masks while irq active
        wr(3'd3, '0);
        step('0, 1'b0, 1'b0, '0, '0);
        wr(3'd0, 32'hA5A5_0003);
        step('0, 1'b0, 1'b0, '0, '0);
        check(irq_o == 1'b0, "R9 irq dropped", N'(irq_o), 0);
        rd(3'd3);
        rd(3'd0);

        // R12: unmapped offsets; read data holds between reads
        wr(3'd6, 32'h1234_5678);
        wr(3'd7, 32'h0);
        rd(3'd6);
        rd(3'd7);
        held = rdata_o;
        step('0, 1'b0, 1'b0, '0, '0);
        check(rdata_o == held, "R12 hold", rdata_o, held);
        for (int a = 0; a < 6; a++) rd(AW'(a));

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            logic [N-1:0] s;
            int op;
            s  = ($urandom % 4 == 0) ? ($urandom & $urandom & $urandom) : '0;
            op = $urandom % 10;
            if (op < 4)
                step(s, 1'b1, 1'b0, AW'($urandom), '0);
            else if (op < 8) begin
                logic [AW-1:0] a;
                a = AW'($urandom);
                if (a == 3'd0 && ($urandom % 4 != 0)) a = 3'd1;
                step(s, 1'b1, 1'b1, a, ($urandom % 2) ? $urandom : ~($urandom & $urandom));
            end else
                step(s, 1'b0, 1'b0, '0, '0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule